// File: doc/BRIEF.md
# Page Staging Buffer and Commit Sequencer

This block sits between the byte-level protocol engine of a serial nonvolatile memory and its storage array. During a write transaction the engine first loads a start address. Each data byte it then receives goes into a 16-entry staging buffer. The slot is picked by the in-page offset, and only that offset advances, so the page number never changes inside a transaction. When the engine sees the closing stop condition it raises a commit request. The sequencer then rewrites the whole addressed page into the array, one byte per clock. Bytes that the transaction did not supply are first read back from the array and written again unchanged. After the copy, a busy flag stays high for a programmable write-cycle time, and the engine uses it to withhold acknowledges.

The write-protect input blocks every commit, across the whole address range. Reads from the array do not pass through this block. An abort request, which the engine raises on a repeated start before any stop, throws away whatever is staged. The write-cycle time is a parameter counted in system clocks. In silicon it is set to the clock rate times the maximum programming time of 5 ms. Simulation uses a short value.

Top module: `page_write_stager`

## Requirements
- R1: While reset is held and after it is released, `busy` and `arr_we` are low until a commit is accepted.
- R2: An accepted `addr_load` takes the page number from `addr_in[10:4]` and the write offset from `addr_in[3:0]`, and discards any staged bytes. Each accepted `byte_stb` stores `byte_data` at the current offset, then adds one to the offset modulo 16, leaving the page number unchanged.
- R3: When more than 16 bytes arrive in one transaction, the offset wraps to 0 of the same page. A later byte at an offset replaces the earlier one, and the last byte written at each offset is the one committed.
- R4: An accepted commit performs exactly 16 array writes on consecutive clocks, at offsets 0 through 15 in ascending order, all inside the page that starts at page number times 16. No address outside that page is written.
- R5: Offsets that received no byte in the transaction keep their previous array contents after the commit.
- R6: `busy` rises on the clock after an accepted commit and stays high for exactly PAGE_BYTES + 1 + WCYCLE_CLKS cycles. It then falls, and the staged bytes are cleared.
- R7: A commit while `wr_prot` is high writes nothing and leaves `busy` low. It also discards the staged bytes.
- R8: An `abort` while not busy discards the staged bytes without any array write or `busy`. When `abort` and `commit` arrive together, `abort` wins.
- R9: A commit with no staged bytes writes nothing and leaves `busy` low.
- R10: `addr_load`, `byte_stb`, `commit` and `abort` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_prot | input | 1 | High blocks all commits |
| addr_load | input | 1 | Strobe: take start address of a write transaction |
| addr_in | input | 11 | Start address (page number and in-page offset) |
| byte_stb | input | 1 | Strobe: one received data byte |
| byte_data | input | 8 | Received data byte |
| commit | input | 1 | Stop seen: program the staged page |
| abort | input | 1 | Repeated start seen: drop staged bytes |
| busy | output | 1 | Copy or write cycle in progress |
| arr_raddr | output | 11 | Array read address, data returned next clock |
| arr_rdata | input | 8 | Array read data, one clock after the address |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions take two things for granted about the surroundings. First, the array returns read data exactly one clock after the address, with a write and a read to different addresses in the same clock not disturbing each other. Second, the write-cycle parameter is at least one. The bench meets the first by modelling the array as a clocked memory with that latency. It drives each strobe for a single clock at a falling edge, never raises `abort` and `commit` together, and holds `wr_prot` steady around each commit, so the expected outcome of every commit is never in doubt. Stray strobes are sent only inside the busy window, which is the case R10 is about.

// File: rtl/pgw_pkg.sv
// Shared types for the page staging buffer and commit sequencer.
package pgw_pkg;
    // Sequencer phases: waiting, copying the page, timing the write cycle.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pgw_stage.sv
// Staging store for one page.
// Holds the page number, a wrapping write offset, one data register and
// one valid flag per in-page offset.
// Assumes: PAGE_BYTES is a power of two; load_en, byte_en and clear are
// never active together (the top module gates them).
module pgw_stage #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_en,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              clear,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [PAGE_W-1:0] page_q,
    output logic              mask_any,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_valid
);
    logic [OFF_W-1:0]      wptr;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     cells [PAGE_BYTES];

    // Page number and write offset; the offset wraps inside the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            wptr   <= '0;
        end else if (load_en) begin
            page_q <= addr_in[ADDR_W-1:OFF_W];
            wptr   <= addr_in[OFF_W-1:0];
        end else if (byte_en) begin
            wptr   <= wptr + 1'b1;
        end
    end

    // Valid flags: cleared on a new transaction or a drop, set per stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (clear || load_en) begin
            mask <= '0;
        end else if (byte_en) begin
            mask[wptr] <= 1'b1;
        end
    end

    // One data register per offset; the newest byte at an offset wins.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (byte_en && (wptr == OFF_W'(g))) begin
                cells[g] <= byte_data;
            end
        end
    end

    // Read side used by the sequencer during the copy.
    always_comb begin
        rd_byte  = cells[rd_off];
        rd_valid = mask[rd_off];
        mask_any = |mask;
    end
endmodule

// File: rtl/pgw_seq.sv
// Commit sequencer.
// On an accepted commit it reads each array byte of the page and writes
// back either the staged byte or the value just read, one offset per clock.
// It then counts the write-cycle time.
// Assumes: array read data arrives one clock after the address;
// WCYCLE_CLKS >= 1.
module pgw_seq #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int WCYCLE_CLKS = 64,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - OFF_W,
    localparam int IDX_W      = OFF_W + 1,
    localparam int CNT_W      = $clog2(WCYCLE_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_req,
    input  logic              abort_req,
    input  logic              wr_prot,
    input  logic              mask_any,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              busy,
    output logic              clear,
    output logic [OFF_W-1:0]  rd_off,
    output logic [ADDR_W-1:0] arr_raddr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata
);
    import pgw_pkg::*;

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             idle;
    logic             start;
    logic             copy_done;

    // Accept and drop decisions, taken only while idle.
    always_comb begin
        idle      = (state == ST_IDLE);
        start     = idle && commit_req && !abort_req && mask_any && !wr_prot;
        copy_done = (state == ST_COPY) && (idx == IDX_W'(PAGE_BYTES));
        clear     = (idle && (abort_req || (commit_req && !start))) || copy_done;
        busy      = !idle;
    end

    // Phase, copy index and write-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_COPY;
                        idx   <= '0;
                    end
                end
                ST_COPY: begin
                    if (copy_done) begin
                        state <= ST_WAIT;
                        cnt   <= CNT_W'(WCYCLE_CLKS - 1);
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pipelined copy: read offset idx, write offset idx-1 in the same clock.
    always_comb begin
        rd_off    = OFF_W'(idx - 1'b1);
        arr_raddr = {page_q, idx[OFF_W-1:0]};
        arr_we    = (state == ST_COPY) && (idx != '0);
        arr_waddr = {page_q, rd_off};
        arr_wdata = rd_valid ? rd_byte : arr_rdata;
    end
endmodule

// File: rtl/page_write_stager.sv
// Page staging buffer with commit sequencer (top).
// Gates the protocol-engine strobes with busy, routes them to the staging
// store, and drives the array ports through the sequencer.
// Assumes: the array has a one-clock read latency; the engine does not
// raise addr_load, byte_stb and commit in the same clock.
module page_write_stager #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int WCYCLE_CLKS = 64,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_prot,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata
);
    logic              load_en;
    logic              byte_en;
    logic              clear;
    logic              mask_any;
    logic              rd_valid;
    logic [OFF_W-1:0]  rd_off;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] rd_byte;

    // Strobes are honoured only while idle; abort and load take precedence.
    always_comb begin
        load_en = addr_load && !busy && !abort;
        byte_en = byte_stb && !busy && !abort && !addr_load && !commit;
    end

    pgw_stage #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .addr_in(addr_in),
        .byte_en(byte_en), .byte_data(byte_data),
        .clear(clear), .rd_off(rd_off),
        .page_q(page_q), .mask_any(mask_any),
        .rd_byte(rd_byte), .rd_valid(rd_valid)
    );

    pgw_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
        .WCYCLE_CLKS(WCYCLE_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .commit_req(commit), .abort_req(abort), .wr_prot(wr_prot),
        .mask_any(mask_any), .page_q(page_q),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .arr_rdata(arr_rdata),
        .busy(busy), .clear(clear), .rd_off(rd_off),
        .arr_raddr(arr_raddr), .arr_we(arr_we),
        .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );
endmodule

// File: rtl/pgw_checker.sv
// Property checker for page_write_stager, attached by bind.
// Tracks the length of each busy window and the writes inside it with
// counters, so no long delay or $past depth is needed.
module pgw_checker #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 16,
    parameter int WCYCLE_CLKS = 64,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int BUSY_CYCLES = PAGE_BYTES + 1 + WCYCLE_CLKS,
    localparam int RUN_W      = $clog2(BUSY_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_waddr,
    input logic              commit,
    input logic              abort,
    input logic              wr_prot
);
    logic [RUN_W-1:0] busy_run;
    logic [RUN_W-1:0] wr_run;

    // Count clocks and array writes inside the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_run <= '0;
            wr_run   <= '0;
        end else begin
            busy_run <= busy_run + 1'b1;
            wr_run   <= wr_run + RUN_W'(arr_we);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !busy && !arr_we);

    assert_write_inside_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_first_write_offset_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && !$past(arr_we) |-> arr_waddr[OFF_W-1:0] == '0);

    assert_write_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we && $past(arr_we) |-> arr_waddr == ADDR_W'($past(arr_waddr) + 1'b1));

    assert_write_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> wr_run == RUN_W'(PAGE_BYTES));

    assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == RUN_W'(BUSY_CYCLES));

    assert_protect_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit && wr_prot && !busy |=> !busy);

    assert_abort_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort && !busy |=> !busy);
endmodule

bind page_write_stager pgw_checker #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WCYCLE_CLKS(WCYCLE_CLKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .commit(commit), .abort(abort), .wr_prot(wr_prot)
);

// File: tb/sim_page_write_stager.sv
`timescale 1ns/1ps
module sim_page_write_stager;
    localparam int WC    = 64;
    localparam int BUSYN = 16 + 1 + WC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_prot = 1'b0, addr_load = 1'b0, byte_stb = 1'b0;
    logic        commit = 1'b0, abort = 1'b0;
    logic [10:0] addr_in = '0;
    logic [7:0]  byte_data = '0;
    logic        busy, arr_we;
    logic [10:0] arr_raddr, arr_waddr;
    logic [7:0]  arr_rdata, arr_wdata;

    logic [7:0]  mem     [2048];
    logic [7:0]  exp_mem [2048];
    logic [7:0]  m_buf   [16];
    logic [15:0] m_mask;
    logic [6:0]  m_page;
    logic [3:0]  m_off;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    page_write_stager #(.WCYCLE_CLKS(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_prot(wr_prot),
        .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_data(byte_data),
        .commit(commit), .abort(abort), .busy(busy),
        .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    // Array model with one-clock read latency.
    always @(posedge clk) begin
        arr_rdata <= mem[arr_raddr];
        if (arr_we) mem[arr_waddr] <= arr_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Compare the whole array against the expected image.
    task automatic check_mem(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < 2048; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, first, -1);
    endtask

    task automatic start_txn(input logic [10:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
        m_page = a[10:4]; m_off = a[3:0]; m_mask = '0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
        m_buf[m_off] = d; m_mask[m_off] = 1'b1; m_off = m_off + 1'b1;
    endtask

    // Commit, check busy timing and array image; inject stray strobes if asked.
    task automatic do_commit(input string req, input bit inject);
        bit exp_busy = (m_mask != 0) && !wr_prot;
        int n = 0;
        if (exp_busy)
            for (int i = 0; i < 16; i++)
                if (m_mask[i]) exp_mem[{m_page, 4'(i)}] = m_buf[i];
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
        chk(busy == exp_busy, req, int'(busy), int'(exp_busy));
        while (busy && n < 1000) begin
            n++;
            addr_load = inject && (n == 2);
            addr_in   = 11'h3A5;
            byte_stb  = inject && (n >= 4) && (n < 8);
            byte_data = 8'hEE;
            @(negedge clk);
        end
        addr_load = 1'b0; byte_stb = 1'b0;
        if (exp_busy) chk(n == BUSYN, "R6", n, BUSYN);
        repeat (2) @(negedge clk);
        check_mem(req);
        m_mask = '0;
    endtask

    task automatic do_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        chk(!busy, "R8", int'(busy), 0);
        m_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7011));
        for (int i = 0; i < 2048; i++) begin
            mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = mem[i];
        end
        m_mask = '0; m_page = '0; m_off = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !arr_we, "R1", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !arr_we, "R1", int'(arr_we), 0);

        // R2 and R5: single byte in the middle of a page.
        start_txn(11'h125); put_byte(8'h5A);
        do_commit("R2", 1'b0);
        // R4: full page from offset 0.
        start_txn(11'h7F0);
        for (int i = 0; i < 16; i++) put_byte(8'(8'hC0 + i));
        do_commit("R4", 1'b0);
        // R3: 20 bytes from offset 12 wrap and overwrite.
        start_txn(11'h04C);
        for (int i = 0; i < 20; i++) put_byte(8'(i + 1));
        do_commit("R3", 1'b0);
        // R7: protected commit.
        wr_prot = 1'b1;
        start_txn(11'h200); put_byte(8'h11); put_byte(8'h22);
        do_commit("R7", 1'b0);
        wr_prot = 1'b0;
        // R8: abort then commit of the same page.
        start_txn(11'h310); put_byte(8'h33);
        do_abort();
        do_commit("R8", 1'b0);
        // R9: empty commit.
        start_txn(11'h400);
        do_commit("R9", 1'b0);
        // R10: strobes during busy are ignored.
        start_txn(11'h560); put_byte(8'h77);
        do_commit("R5", 1'b1);
        do_commit("R10", 1'b0);

        // Random transactions.
        for (int t = 0; t < 30; t++) begin
            int nb = int'($urandom_range(0, 20));
            int kind = int'($urandom_range(0, 9));
            start_txn(11'($urandom));
            for (int b = 0; b < nb; b++) put_byte(8'($urandom));
            if (kind == 0) begin
                do_abort();
                do_commit("R8", 1'b0);
            end else begin
                wr_prot = (kind == 1);
                do_commit(wr_prot ? "R7" : "R5", 1'b0);
                wr_prot = 1'b0;
            end
        end
        summary();
        $finish;
    end
endmodule